// File: doc/BRIEF.md
# Periodic Tick Interrupt Reinjection Controller

This block sits between a periodic timer tick source and a single interrupt line. Every timer expiration that has not yet been delivered is recorded in a backlog counter. The counter shrinks only when the consumer acknowledges an interrupt. A new interrupt pulse goes out only after the previous one has been acknowledged, so the consumer never sees a pulse it has not made room for.

A mode input selects how a backlog is handled. In replay mode every lost tick is kept and delivered later, one per acknowledge. In collapse mode any backlog is folded into a single outstanding tick. Reloading the timer, or unmasking the interrupt at the consumer, throws the backlog away and re-arms delivery. The interface carries no data stream: every pin is a plain control or status level, sampled on the rising clock edge. The backlog is visible on an observation port.

Top module: `tick_reinj_ctrl`

## Requirements
- R1: After reset the pending count is 0, `irq_o` is low, and delivery is armed: the first tick produces a pulse with no acknowledge needed.
- R2: In replay mode (`reinject_en_i`=1), a tick with no acknowledge and no clear adds one to the pending count at the next edge.
- R3: In replay mode the pending count saturates at 2^CNT_W-1. A further tick leaves it there instead of wrapping.
- R4: In collapse mode (`reinject_en_i`=0), a tick with no clear sets the pending count to exactly 1, whatever its previous value and whether or not an acknowledge is present.
- R5: An acknowledge with no tick and no clear lowers the pending count by one and never below 0. Every acknowledge re-arms delivery.
- R6: A pulse is issued only when the pending count is nonzero and delivery is armed. Issuing disarms delivery, so no further pulse appears until an acknowledge arrives.
- R7: A load-restart or unmask input clears the pending count to 0 and re-arms delivery at the next edge. It takes priority over a tick or an acknowledge in the same cycle, and no pulse is issued in that cycle.
- R8: In replay mode, a tick and an acknowledge in the same cycle leave the pending count unchanged, and delivery is re-armed.
- R9: Each pulse on `irq_o` is high for exactly one cycle and is always followed by at least one low cycle, so every interrupt forms a rising edge.
- R10: `irq_o` rises on the edge after the cycle in which the pending count is nonzero, delivery is armed and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timer expiration strobe |
| ack_i | input | 1 | One-cycle interrupt acknowledge strobe |
| unmask_i | input | 1 | Strobe: consumer unmasked the interrupt; clears backlog |
| reinject_en_i | input | 1 | 1 = replay every missed tick, 0 = collapse backlog to one |
| load_restart_i | input | 1 | Strobe: timer count reloaded; clears backlog |
| irq_o | output | 1 | Interrupt pulse, one cycle wide |
| pending_o | output | CNT_W | Current pending tick count |

## Verification
The bench compares against a reference model on every cycle and goes after the simultaneous cases. A tick together with an acknowledge must hold the count; a design that applied only one of them would drift the backlog up or down. A clear together with a tick must leave zero; a design that let the tick win would start a fresh interrupt from a stale backlog. The bench also drives the counter into saturation, where a wrapping counter would silently drop fifteen ticks. It acknowledges on the very cycle a pulse rises, where a design without the low-gap rule would hold `irq_o` high for two cycles and lose an edge. Collapse mode is checked with a deep backlog, which must read 1 after the next tick rather than one more than before.

// File: rtl/tick_reinj_pkg.sv
package tick_reinj_pkg;
  // Update applied to the pending counter at the next edge
  typedef enum logic [2:0] {
    PEND_HOLD = 3'd0,
    PEND_INC  = 3'd1,
    PEND_DEC  = 3'd2,
    PEND_ONE  = 3'd3,
    PEND_ZERO = 3'd4
  } pend_op_e;
endpackage

// File: rtl/tick_reinj_decode.sv
module tick_reinj_decode
  import tick_reinj_pkg::*;
(
  input  logic     tick,
  input  logic     ack,
  input  logic     clear,
  input  logic     reinject_en,
  output pend_op_e op
);
  // Priority: clear (R7) > collapse tick (R4) > tick+ack hold (R8) > tick (R2) > ack (R5)
  always_comb begin
    if (clear)                    op = PEND_ZERO;
    else if (tick && !reinject_en) op = PEND_ONE;
    else if (tick && ack)          op = PEND_HOLD;
    else if (tick)                 op = PEND_INC;
    else if (ack)                  op = PEND_DEC;
    else                           op = PEND_HOLD;
  end
endmodule

// File: rtl/tick_reinj_counter.sv
module tick_reinj_counter
  import tick_reinj_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pend_op_e         op,
  output logic [CNT_W-1:0] count,
  output logic             nonzero
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    unique case (op)
      PEND_INC:  if (cnt_q != CNT_MAX)  cnt_d = cnt_q + CNT_ONE;
      PEND_DEC:  if (cnt_q != CNT_ZERO) cnt_d = cnt_q - CNT_ONE;
      PEND_ONE:  cnt_d = CNT_ONE;
      PEND_ZERO: cnt_d = CNT_ZERO;
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_ZERO;
    else        cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign nonzero = (cnt_q != CNT_ZERO);
endmodule

// File: rtl/tick_reinj_gate.sv
module tick_reinj_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic ack,
  input  logic pending_nz,
  output logic irq
);
  logic armed_q, irq_q, issue;

  // Fire from registered state only; the low-gap term keeps pulses one cycle wide
  assign issue = pending_nz & armed_q & ~irq_q & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= issue;
      if (clear || ack) armed_q <= 1'b1;
      else if (issue)   armed_q <= 1'b0;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/tick_reinj_ctrl.sv
module tick_reinj_ctrl
  import tick_reinj_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ack_i,
  input  logic             unmask_i,
  input  logic             reinject_en_i,
  input  logic             load_restart_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] pending_o
);
  pend_op_e op;
  logic     clear;
  logic     pending_nz;

  assign clear = unmask_i | load_restart_i;

  tick_reinj_decode u_decode (
    .tick        (tick_i),
    .ack         (ack_i),
    .clear       (clear),
    .reinject_en (reinject_en_i),
    .op          (op)
  );

  tick_reinj_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .count   (pending_o),
    .nonzero (pending_nz)
  );

  tick_reinj_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .ack        (ack_i),
    .pending_nz (pending_nz),
    .irq        (irq_o)
  );
endmodule

// File: rtl/tick_reinj_ctrl_checker.sv
module tick_reinj_ctrl_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             ack_i,
  input logic             unmask_i,
  input logic             reinject_en_i,
  input logic             load_restart_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] pending_o
);
  localparam logic [CNT_W-1:0] CHK_MAX = {CNT_W{1'b1}};
  logic clr;
  assign clr = unmask_i | load_restart_i;

  assert_pulse_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pending_o == '0) && !irq_o);

  assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o == CHK_MAX && tick_i && !ack_i && !clr && reinject_en_i)
      |=> pending_o == CHK_MAX);

  assert_collapse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !reinject_en_i && !clr) |=> pending_o == CNT_W'(1));

  assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !tick_i && !clr && pending_o == '0) |=> pending_o == '0);

  assert_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o == '0) |=> !irq_o);

  assert_tick_ack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && ack_i && reinject_en_i && !clr) |=> $stable(pending_o));
endmodule

bind tick_reinj_ctrl tick_reinj_ctrl_checker #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick_i         (tick_i),
  .ack_i          (ack_i),
  .unmask_i       (unmask_i),
  .reinject_en_i  (reinject_en_i),
  .load_restart_i (load_restart_i),
  .irq_o          (irq_o),
  .pending_o      (pending_o)
);

// File: tb/tick_reinj_ctrl_test.sv
module tick_reinj_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;
  localparam int MAXV = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, ack = 0, unm = 0, rj = 1, ld = 0;
  logic irq;
  logic [CNT_W-1:0] pend;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int  m_cnt  = 0;
  bit  m_arm  = 1;
  bit  m_irq  = 0;
  bit  prev_irq = 0;
  string cyc_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_reinj_ctrl #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ack_i(ack), .unmask_i(unm),
    .reinject_en_i(rj), .load_restart_i(ld), .irq_o(irq), .pending_o(pend)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Advance the model by one edge for the inputs currently driven
  task automatic model_step();
    bit clr, issue;
    clr = unm | ld;
    issue = (m_cnt != 0) && m_arm && !m_irq && !clr;
    if (clr)                  begin m_cnt = 0; cyc_tag = "R7"; end
    else if (tick && !rj)     begin m_cnt = 1; cyc_tag = "R4"; end
    else if (tick && ack)     cyc_tag = "R8";
    else if (tick)            begin if (m_cnt < MAXV) m_cnt++; cyc_tag = "R2"; end
    else if (ack)             begin if (m_cnt > 0) m_cnt--; cyc_tag = "R5"; end
    else                      cyc_tag = "R6";
    if (clr || ack) m_arm = 1;
    else if (issue) m_arm = 0;
    m_irq = issue;
  endtask

  // Drive at negedge, clock once, compare at the following negedge
  task automatic step(input bit t, input bit a, input bit u, input bit l, input bit r);
    tick = t; ack = a; unm = u; ld = l; rj = r;
    model_step();
    @(negedge clk);
    check(cyc_tag, int'(pend), m_cnt, "pending_o");
    check("R6", int'(irq), int'(m_irq), "irq_o");
    if (prev_irq && irq) check("R9", 1, 0, "irq_o high two cycles");
    prev_irq = irq;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(pend), 0, "pending_o in reset");
    check("R1", int'(irq), 0, "irq_o in reset");
    rst_n = 1'b1;

    // R1/R10: single tick fires with no prior acknowledge, one edge after count is 1
    step(1, 0, 0, 0, 1);
    check("R2", int'(pend), 1, "pending after one tick");
    check("R10", int'(irq), 0, "irq not yet");
    step(0, 0, 0, 0, 1);
    check("R10", int'(irq), 1, "irq rises one edge later");
    step(0, 0, 0, 0, 1);
    check("R9", int'(irq), 0, "pulse one cycle wide");
    // R6: no second pulse without ack, even with backlog
    step(1, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    check("R6", int'(irq), 0, "no pulse while disarmed");
    // ack re-arms, pulse follows
    step(0, 1, 0, 0, 1);
    check("R5", int'(pend), 1, "ack decrements");
    step(0, 0, 0, 0, 1);
    check("R6", int'(irq), 1, "pulse after ack");
    // ack on the cycle irq is high: must still drop for a cycle (R9)
    step(0, 1, 0, 0, 1);
    check("R9", int'(irq), 0, "gap after pulse");

    // R3: saturation
    for (int i = 0; i < MAXV + 4; i++) step(1, 0, 0, 0, 1);
    check("R3", int'(pend), MAXV, "saturated count");
    // R8 at saturation: unchanged
    step(1, 1, 0, 0, 1);
    check("R8", int'(pend), MAXV, "tick+ack hold");
    // R4: collapse with deep backlog
    step(1, 0, 0, 0, 0);
    check("R4", int'(pend), 1, "collapse to one");
    // R7: clear beats tick
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 1);
    step(1, 0, 0, 1, 1);
    check("R7", int'(pend), 0, "load-restart clears");
    step(1, 0, 0, 0, 1);
    step(1, 1, 1, 0, 1);
    check("R7", int'(pend), 0, "unmask clears");
    check("R7", int'(irq), 0, "no pulse on clear");
    // R5 floor
    step(0, 1, 0, 0, 1);
    step(0, 1, 0, 0, 1);
    check("R5", int'(pend), 0, "floor at zero");

    // random traffic compared every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 40) == 0,
           ($urandom % 40) == 0, (i / 500) % 2 == 0 ? 1'b1 : (($urandom % 8) != 0 ? 1'b0 : 1'b1));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule